// File: doc/BRIEF.md
# Pairwise Widening Vector Adder

This execution unit takes one packed source vector and sums each neighbouring pair of elements, so that every two source elements produce one element of double width in the result. The pair sum is sign-extended or zero-extended before the add, and may be added onto the double-width element already held in the destination vector, in which case it wraps. The operation is selected by a 32-bit instruction word, which the unit decodes itself. The caller supplies the source vector and the current destination contents read from its register file.

A request is taken on a valid/ready handshake and the result comes back one clock later from an output register. It stays there, with a valid strobe, until the consumer takes it. The controller has two states. `ST_EMPTY` means the output register holds nothing. `ST_HELD` means it holds a result that is waiting to be taken. Transitions:
- `ST_EMPTY` to `ST_HELD`: a request is accepted.
- `ST_HELD` to `ST_HELD`: the result is not taken, or it is taken in the same cycle as a new request is accepted.
- `ST_HELD` to `ST_EMPTY`: the result is taken and no new request is offered.

Top module: `pairwise_widen_add`

## Requirements
- R1: Instruction bits 23:22 set the source element width: 00 gives 8 bits, 01 gives 16 bits and 10 gives 32 bits. Result element e occupies the e-th slot of twice the source width, counted from bit 0. It equals source element 2e plus source element 2e+1.
- R2: Instruction bit 30 selects the vector length: 1 gives 128 bits and 0 gives 64 bits. In the 64-bit form only the low 64 source bits are used and result bits 127:64 are zero.
- R3: Instruction bit 29 picks the extension: 0 sign-extends both source elements before the add and 1 zero-extends them.
- R4: Instruction bits 16:10 equal to 0011010 select accumulate mode. Each pair sum is added to the matching double-width destination element, and the result wraps modulo 2 to the power of the result element width.
- R5: Bits 16:10 equal to 0001010 select plain mode. The destination input has no effect, and each result element is just the widened pair sum.
- R6: A legal instruction, with bits 23:22 not equal to 11, has masked form (instruction AND 0xBF3FFC00) equal to one of 0x0E202800, 0x0E206800, 0x2E202800 or 0x2E206800. Any other word gives write enable 0 and illegal flag 0, and the result equals the destination input.
- R7: A matching word with bits 23:22 equal to 11 gives illegal flag 1 and write enable 0, and the result equals the destination input. A legal word gives write enable 1 and illegal flag 0.
- R8: A request accepted on a clock edge shows its result with rsp_valid high right after that edge.
- R9: While rsp_valid is high and rsp_ready is low, all of the following hold: req_ready is low, the response outputs hold steady, and rsp_valid stays high.
- R10: After reset rsp_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_insn | input | 32 | Instruction word |
| req_src | input | 128 | Source vector |
| req_dst | input | 128 | Current destination vector |
| rsp_valid | output | 1 | Result held |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 128 | New destination value |
| rsp_wr_en | output | 1 | Destination should be written |
| rsp_illegal | output | 1 | Reserved element-size encoding |

## Verification
Every result is due one clock after the edge on which its request is accepted. The driver finds that edge by reading req_ready shortly after the falling edge. It pushes the expected value into the scoreboard at that moment, and checks rsp_valid one nanosecond after the accepting rising edge. The monitor compares a result only on the falling edge before the rising edge that takes it. During the random back-pressure phase it checks that a stalled response stays steady and that req_ready stays low.

// File: rtl/pwa_pkg.sv
package pwa_pkg;
    localparam int INSN_W = 32;

    typedef enum logic [1:0] {
        SZ_B8   = 2'b00,
        SZ_H16  = 2'b01,
        SZ_W32  = 2'b10,
        SZ_RSVD = 2'b11
    } esize_e;

    typedef struct packed {
        logic   hit;
        logic   reserved;
        logic   wide;
        logic   unsgn;
        logic   accum;
        esize_e size;
    } op_dec_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } state_e;
endpackage

// File: rtl/pwa_decode.sv
module pwa_decode
    import pwa_pkg::*;
(
    input  logic [INSN_W-1:10] insn,
    output op_dec_t            dec
);
    logic fixed_ok;

    always_comb begin
        fixed_ok = (insn[31] == 1'b0) && (insn[28:24] == 5'b01110)
                && (insn[21:15] == 7'b1000000) && (insn[13:10] == 4'b1010);
        dec.hit      = fixed_ok;
        dec.size     = esize_e'(insn[23:22]);
        dec.reserved = fixed_ok && (insn[23:22] == 2'b11);
        dec.wide     = insn[30];
        dec.unsgn    = insn[29];
        dec.accum    = insn[14];
    end
endmodule

// File: rtl/pwa_lane.sv
module pwa_lane #(
    parameter int EW = 8
) (
    input  logic [EW-1:0]   elem_lo,
    input  logic [EW-1:0]   elem_hi,
    input  logic [2*EW-1:0] acc_in,
    input  logic            unsgn,
    input  logic            accum,
    output logic [2*EW-1:0] sum
);
    logic [2*EW-1:0] lo_x, hi_x, base;

    always_comb begin
        lo_x = {{EW{~unsgn & elem_lo[EW-1]}}, elem_lo};
        hi_x = {{EW{~unsgn & elem_hi[EW-1]}}, elem_hi};
        base = accum ? acc_in : '0;
        sum  = lo_x + hi_x + base;
    end
endmodule

// File: rtl/pwa_vec.sv
module pwa_vec #(
    parameter int EW    = 8,
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] src,
    input  logic [VEC_W-1:0] dst,
    input  logic             unsgn,
    input  logic             accum,
    output logic [VEC_W-1:0] res
);
    localparam int RW    = 2 * EW;
    localparam int LANES = VEC_W / RW;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        pwa_lane #(.EW(EW)) u_lane (
            .elem_lo (src[(2*e)*EW +: EW]),
            .elem_hi (src[(2*e+1)*EW +: EW]),
            .acc_in  (dst[e*RW +: RW]),
            .unsgn   (unsgn),
            .accum   (accum),
            .sum     (res[e*RW +: RW])
        );
    end
endmodule

// File: rtl/pairwise_widen_add.sv
module pairwise_widen_add
    import pwa_pkg::*;
#(
    parameter int VEC_W     = 128,
    parameter int NUM_SIZES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_insn,
    input  logic [VEC_W-1:0]  req_src,
    input  logic [VEC_W-1:0]  req_dst,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [VEC_W-1:0]  rsp_data,
    output logic              rsp_wr_en,
    output logic              rsp_illegal
);
    localparam int HALF_W = VEC_W / 2;

    op_dec_t          dec;
    logic [VEC_W-1:0] by_size [NUM_SIZES];
    logic [VEC_W-1:0] picked, result_d;
    logic             wr_d, ill_d, accept;
    state_e           state, state_nx;
    logic             wide_q;

    pwa_decode u_dec (.insn(req_insn[31:10]), .dec(dec));

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        pwa_vec #(.EW(8 << s), .VEC_W(VEC_W)) u_vec (
            .src   (req_src),
            .dst   (req_dst),
            .unsgn (dec.unsgn),
            .accum (dec.accum),
            .res   (by_size[s])
        );
    end

    always_comb begin
        picked = by_size[0];
        for (int s = 1; s < NUM_SIZES; s++)
            if (int'(dec.size) == s) picked = by_size[s];
        if (!dec.wide) picked[VEC_W-1:HALF_W] = '0;
        wr_d     = dec.hit && !dec.reserved;
        ill_d    = dec.reserved;
        result_d = wr_d ? picked : req_dst;
    end

    assign rsp_valid = (state == ST_HELD);
    assign req_ready = (state == ST_EMPTY) || rsp_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (accept) state_nx = ST_HELD;
            ST_HELD:  if (rsp_ready && !req_valid) state_nx = ST_EMPTY;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_data    <= '0;
            rsp_wr_en   <= 1'b0;
            rsp_illegal <= 1'b0;
            wide_q      <= 1'b0;
        end else if (accept) begin
            rsp_data    <= result_d;
            rsp_wr_en   <= wr_d;
            rsp_illegal <= ill_d;
            wide_q      <= dec.wide;
        end
    end

    // R8
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);

    // R9
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)
                                       && $stable(rsp_wr_en) && $stable(rsp_illegal)));

    // R2
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_wr_en && !wide_q) |-> (rsp_data[VEC_W-1:HALF_W] == '0));

    // R7
    flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_wr_en && rsp_illegal));
endmodule

// File: tb/pairwise_widen_add_tb.sv
`timescale 1ns/1ps
module pairwise_widen_add_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_insn = '0;
    logic [127:0] req_src = '0;
    logic [127:0] req_dst = '0;
    logic         rsp_valid;
    logic         rsp_ready = 1'b1;
    logic [127:0] rsp_data;
    logic         rsp_wr_en;
    logic         rsp_illegal;

    int checks = 0;
    int errors = 0;
    bit bp_mode = 1'b0;
    bit done = 1'b0;

    logic [129:0] exp_q [$];
    string        tag_q [$];

    always #2.5 clk = ~clk;

    pairwise_widen_add u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_insn(req_insn),
        .req_src(req_src), .req_dst(req_dst),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_wr_en(rsp_wr_en), .rsp_illegal(rsp_illegal)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [129:0] model(input logic [31:0] insn, input logic [127:0] src,
                                           input logic [127:0] dst);
        logic [31:0]  m;
        logic [127:0] res;
        int ew, vw, n;
        bit sgn, acc;
        m = insn & 32'hBF3FFC00;
        if (!(m == 32'h0E202800 || m == 32'h0E206800 || m == 32'h2E202800 || m == 32'h2E206800))
            return {dst, 2'b00};
        if (insn[23:22] == 2'b11) return {dst, 2'b01};
        ew  = 8 << insn[23:22];
        vw  = insn[30] ? 128 : 64;
        n   = vw / (2 * ew);
        sgn = !insn[29];
        acc = insn[14];
        res = '0;
        for (int e = 0; e < n; e++) begin
            longint a = 0, b = 0, d = 0, s;
            for (int k = 0; k < ew; k++) begin
                a[k] = src[2*e*ew + k];
                b[k] = src[(2*e+1)*ew + k];
            end
            if (sgn && a[ew-1]) a = a - (longint'(1) << ew);
            if (sgn && b[ew-1]) b = b - (longint'(1) << ew);
            if (acc) for (int k = 0; k < 2*ew; k++) d[k] = dst[e*2*ew + k];
            s = a + b + d;
            for (int k = 0; k < 2*ew; k++) res[e*2*ew + k] = s[k];
        end
        return {res, 2'b10};
    endfunction

    task automatic send(input logic [31:0] insn, input logic [127:0] src, input logic [127:0] dst,
                        input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_insn = insn; req_src = src; req_dst = dst;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(model(insn, src, dst));
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, "R8 latency", {127'd0, rsp_valid}, 128'd1);
    endtask

    always @(negedge clk) rsp_ready <= bp_mode ? 1'($urandom_range(0, 1)) : 1'b1;

    initial begin : monitor
        bit           was_stalled = 1'b0;
        logic [129:0] held = '0;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && rsp_valid) begin
                if (was_stalled)
                    chk({rsp_data, rsp_wr_en, rsp_illegal} === held, "R9 hold",
                        rsp_data, held[129:2]);
                if (!rsp_ready) begin
                    chk(req_ready === 1'b0, "R9 ready low", {127'd0, req_ready}, 128'd0);
                    was_stalled = 1'b1;
                    held = {rsp_data, rsp_wr_en, rsp_illegal};
                end else begin
                    was_stalled = 1'b0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 unexpected result", rsp_data, '0);
                    end else begin
                        logic [129:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        chk(rsp_data === e[129:2], {t, " data"}, rsp_data, e[129:2]);
                        chk(rsp_wr_en === e[1], {t, " R6 R7 wr_en"}, {127'd0, rsp_wr_en}, {127'd0, e[1]});
                        chk(rsp_illegal === e[0], {t, " R7 illegal"}, {127'd0, rsp_illegal}, {127'd0, e[0]});
                    end
                end
            end else begin
                was_stalled = 1'b0;
            end
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [127:0] mn, src, dst;
        logic [31:0]  insn;
        #12;
        chk(rsp_valid === 1'b0, "R10 rsp_valid", {127'd0, rsp_valid}, 128'd0);
        chk(req_ready === 1'b1, "R10 req_ready", {127'd0, req_ready}, 128'd1);
        rst_n = 1'b1;
        for (int u = 0; u < 2; u++)
            for (int ac = 0; ac < 2; ac++)
                for (int q = 0; q < 2; q++)
                    for (int sz = 0; sz < 3; sz++) begin
                        string tag;
                        tag = $sformatf("R1 R2 R3 %s u=%0d q=%0d sz=%0d", ac ? "R4" : "R5", u, q, sz);
                        insn = (ac ? 32'h0E206800 : 32'h0E202800) | (32'(u) << 29)
                             | (32'(q) << 30) | (32'(sz) << 22) | ($urandom() & 32'h3FF);
                        for (int k = 0; k < 128; k++) mn[k] = ((k % (8 << sz)) == (8 << sz) - 1);
                        for (int r = 0; r < 3; r++) begin
                            src = {$urandom(), $urandom(), $urandom(), $urandom()};
                            dst = {$urandom(), $urandom(), $urandom(), $urandom()};
                            send(insn, src, dst, tag);
                        end
                        send(insn, '1, '1, {tag, " all-ones"});
                        send(insn, mn, mn, {tag, " most-negative"});
                    end
        insn = 32'h2E206800 | (32'd3 << 22);
        send(insn, '1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, "R7 reserved size");
        send(insn | (32'd1 << 30), '1, '0, "R7 reserved size wide");
        send(32'h0E206800 ^ (32'd1 << 12), '1, 128'hDEAD, "R6 bad pattern");
        send(32'h0, '1, 128'hBEEF, "R6 zero word");
        send(32'h4E212800, '1, 128'hCAFE, "R6 bit 16 set");
        bp_mode = 1'b1;
        for (int r = 0; r < 40; r++) begin
            insn = 32'h0E202800 | (32'($urandom_range(0, 2)) << 22) | (32'($urandom_range(0, 3)) << 29)
                 | (32'($urandom_range(0, 1)) << 14);
            send(insn, {$urandom(), $urandom(), $urandom(), $urandom()},
                 {$urandom(), $urandom(), $urandom(), $urandom()}, "R9 backpressure");
        end
        bp_mode = 1'b0;
        for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(negedge clk);
        #3;
        chk(exp_q.size() == 0, "R8 drained", 128'(exp_q.size()), '0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule